// File: doc/BRIEF.md
# Power-Good Strap Latch Controller

This block sits between the board-level power-sequencing pin of a clock generator and the logic that picks output frequencies and output routing. A single multi-purpose control pin does two jobs. Until the platform first reports power good on it, the pin acts as a level-sensitive strobe. On that first report the block records the configuration straps: the three frequency-select bits, the function-select strap, the debug-port select strap and the trusted-mode strap. From then on the same pin is a live power-down request. A mode pin decides which level of the control pin means power good.

The control pin is asynchronous, so it passes through a synchronizer before it is evaluated. Once the straps are recorded they stay fixed, even if the pins change later. The one exception is test mode, where the straps keep following the pins for as long as the power-good level is held. The captured frequency bits are decoded into a CPU frequency code. Codes that have no defined meaning are flagged and fall back to the slowest setting. The function-select and debug-select straps drive the output mux selects. In test mode the captured FSB bit picks either tristated outputs or a divided reference clock.

Top module: `pwrgood_strap_ctrl`

## Requirements
- R1: After reset: `locked_o`=0, `pwrdn_o`=0, `cpu_freq_o`=0 (100 MHz), `freq_rsvd_o`=0, `func_sel_o`=0, `dbg_sel_o`=0, `trusted_o`=1.
- R2: When `pol_mode_i`=0, a low `ctl_pin_i` means power good and a high one means power down. When `pol_mode_i`=1 the meaning is reversed. No capture happens while the pin sits at the power-down level.
- R3: The first power-good level seen after reset records `fs_i` (bit 2 = FSC, bit 1 = FSB, bit 0 = FSA) and the three other straps, and sets `locked_o`. This takes effect no later than the third rising clock edge after the pin change, counted once the synchronizer has filled after reset.
- R4: Once `locked_o`=1 and `test_mode_i`=0, later changes on `fs_i`, the straps or `ctl_pin_i` leave the recorded strap outputs unchanged. `locked_o` stays 1 until reset.
- R5: Once locked, `pwrdn_o` is 1 exactly while the synchronized `ctl_pin_i` is at the power-down level for the current polarity.
- R6: `cpu_freq_o` decodes the captured `{FSC,FSB,FSA}` as follows: 101→0 (100 MHz), 001→1 (133 MHz), 011→2 (166 MHz), 010→3 (200 MHz). For these codes `freq_rsvd_o`=0.
- R7: Every other captured code (000, 100, 110, 111) gives `cpu_freq_o`=0 with `freq_rsvd_o`=1.
- R8: `func_sel_o` (1 = shared pair carries 27 MHz and the other pair carries the display clock; 0 = 96 MHz dot and SRC0), `dbg_sel_o` (1 = CPU2 debug clock, 0 = SRC10) and `trusted_o` (1 = trusted) show the recorded strap values.
- R9: While `test_mode_i`=1 and the pin is at the power-good level, the strap outputs follow the live pins, even after lock.
- R10: While `test_mode_i`=1, the captured FSB gives `test_tristate_o`=1 when it is 0 and `test_refdiv_o`=1 when it is 1. Both outputs are 0 when `test_mode_i`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| ctl_pin_i | input | 1 | Asynchronous strobe / power-down pin |
| pol_mode_i | input | 1 | Polarity select for ctl_pin_i |
| test_mode_i | input | 1 | Test-mode condition |
| fs_i | input | 3 | Frequency straps {FSC,FSB,FSA} |
| func_strap_i | input | 1 | Function-select strap |
| dbg_strap_i | input | 1 | Debug-port select strap |
| trust_strap_i | input | 1 | Trusted-mode strap |
| locked_o | output | 1 | Straps have been recorded |
| pwrdn_o | output | 1 | Live power-down request |
| cpu_freq_o | output | 2 | Decoded CPU frequency code |
| freq_rsvd_o | output | 1 | Captured code is undefined |
| func_sel_o | output | 1 | Output mux select for the shared/display pairs |
| dbg_sel_o | output | 1 | Debug-pair select |
| trusted_o | output | 1 | Trusted mode |
| test_tristate_o | output | 1 | Test mode: tristate outputs |
| test_refdiv_o | output | 1 | Test mode: drive divided reference |

## Verification
The bench checks the one-shot behaviour by changing every strap and toggling the pin after lock. A design that re-armed the capture would pick up the new frequency code. The same scenario runs under both polarities, because a design with an inverted polarity term would either capture while the pin is held at power down or report power down while the pin signals power good. All four defined frequency codes and two undefined ones are applied, to catch a swapped decode entry or a missing reserved flag. Test mode is entered after lock to confirm that the straps follow the pins there, and that the FSB-based output select works and stays silent outside test mode.

// File: rtl/pgs_pkg.sv
package pgs_pkg;

    localparam int FS_W = 3;

    typedef enum logic [1:0] {
        FREQ_100 = 2'd0,
        FREQ_133 = 2'd1,
        FREQ_166 = 2'd2,
        FREQ_200 = 2'd3
    } freq_code_e;

    typedef struct packed {
        logic [FS_W-1:0] fs;     // {FSC,FSB,FSA}
        logic            func;
        logic            dbg;
        logic            trust;
    } strap_t;

    localparam strap_t STRAP_RESET = '{fs: 3'b101, func: 1'b0, dbg: 1'b0, trust: 1'b1};

    typedef struct packed {
        logic   locked;
        strap_t straps;
    } ctrl_state_t;

endpackage

// File: rtl/pgs_sync.sv
module pgs_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o,
    output logic vld_o
);
    logic [STAGES-1:0] data_d, data_q;
    logic [STAGES-1:0] fill_d, fill_q;

    always_comb begin
        data_d = {data_q[STAGES-2:0], async_i};
        fill_d = {fill_q[STAGES-2:0], 1'b1};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
            fill_q <= '0;
        end else begin
            data_q <= data_d;
            fill_q <= fill_d;
        end
    end

    assign sync_o = data_q[STAGES-1];
    assign vld_o  = fill_q[STAGES-1];

    // valid never drops once set
    assert_vld_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        vld_o |=> vld_o);
endmodule

// File: rtl/pgs_freq_decode.sv
module pgs_freq_decode
    import pgs_pkg::*;
(
    input  logic [FS_W-1:0] fs_i,
    output freq_code_e      code_o,
    output logic            rsvd_o
);
    always_comb begin
        rsvd_o = 1'b0;
        case (fs_i)
            3'b101:  code_o = FREQ_100;
            3'b001:  code_o = FREQ_133;
            3'b011:  code_o = FREQ_166;
            3'b010:  code_o = FREQ_200;
            default: begin
                code_o = FREQ_100;
                rsvd_o = 1'b1;
            end
        endcase
    end

    always_comb begin
        assert_rsvd_fallback_R7: assert (!rsvd_o || code_o == FREQ_100);
    end
endmodule

// File: rtl/pwrgood_strap_ctrl.sv
module pwrgood_strap_ctrl
    import pgs_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ctl_pin_i,
    input  logic            pol_mode_i,
    input  logic            test_mode_i,
    input  logic [FS_W-1:0] fs_i,
    input  logic            func_strap_i,
    input  logic            dbg_strap_i,
    input  logic            trust_strap_i,
    output logic            locked_o,
    output logic            pwrdn_o,
    output logic [1:0]      cpu_freq_o,
    output logic            freq_rsvd_o,
    output logic            func_sel_o,
    output logic            dbg_sel_o,
    output logic            trusted_o,
    output logic            test_tristate_o,
    output logic            test_refdiv_o
);
    localparam int FSB_BIT = 1;

    logic        ctl_sync, ctl_vld, pg_good;
    ctrl_state_t st_d, st_q;
    strap_t      live;
    freq_code_e  code;

    pgs_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (ctl_pin_i),
        .sync_o  (ctl_sync),
        .vld_o   (ctl_vld)
    );

    // power good when synchronized level matches the polarity mode
    assign pg_good = ctl_vld & ~(ctl_sync ^ pol_mode_i);

    always_comb begin
        live = '{fs: fs_i, func: func_strap_i, dbg: dbg_strap_i, trust: trust_strap_i};
        st_d = st_q;
        if (pg_good && (!st_q.locked || test_mode_i)) begin
            st_d.straps = live;
            st_d.locked = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.locked <= 1'b0;
            st_q.straps <= STRAP_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    pgs_freq_decode u_dec (
        .fs_i   (st_q.straps.fs),
        .code_o (code),
        .rsvd_o (freq_rsvd_o)
    );

    assign locked_o        = st_q.locked;
    assign pwrdn_o         = st_q.locked & ctl_vld & ~pg_good;
    assign cpu_freq_o      = code;
    assign func_sel_o      = st_q.straps.func;
    assign dbg_sel_o       = st_q.straps.dbg;
    assign trusted_o       = st_q.straps.trust;
    assign test_tristate_o = test_mode_i & ~st_q.straps.fs[FSB_BIT];
    assign test_refdiv_o   = test_mode_i &  st_q.straps.fs[FSB_BIT];

    assert_lock_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        locked_o |=> locked_o);

    assert_straps_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (locked_o && !test_mode_i) |=> $stable(st_q.straps));

    assert_pwrdn_after_lock_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pwrdn_o |-> locked_o);

    assert_lock_needs_good_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked_o) |-> $past(pg_good));

    assert_test_sel_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({test_tristate_o, test_refdiv_o}));
endmodule

// File: tb/pwrgood_strap_ctrl_tb.sv
module pwrgood_strap_ctrl_tb;
    localparam time CLK_PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_pin_i = 1'b1;
    logic       pol_mode_i = 1'b0;
    logic       test_mode_i = 1'b0;
    logic [2:0] fs_i = 3'b000;
    logic       func_strap_i = 1'b0;
    logic       dbg_strap_i = 1'b0;
    logic       trust_strap_i = 1'b0;
    logic       locked_o, pwrdn_o, freq_rsvd_o, func_sel_o, dbg_sel_o, trusted_o;
    logic       test_tristate_o, test_refdiv_o;
    logic [1:0] cpu_freq_o;

    int n_checks = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwrgood_strap_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .ctl_pin_i(ctl_pin_i), .pol_mode_i(pol_mode_i),
        .test_mode_i(test_mode_i), .fs_i(fs_i), .func_strap_i(func_strap_i),
        .dbg_strap_i(dbg_strap_i), .trust_strap_i(trust_strap_i),
        .locked_o(locked_o), .pwrdn_o(pwrdn_o), .cpu_freq_o(cpu_freq_o),
        .freq_rsvd_o(freq_rsvd_o), .func_sel_o(func_sel_o), .dbg_sel_o(dbg_sel_o),
        .trusted_o(trusted_o), .test_tristate_o(test_tristate_o),
        .test_refdiv_o(test_refdiv_o)
    );

    task automatic chk(input string req, input string what, input int got, input int exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    // pd level = 1 when pol 0, 0 when pol 1
    function automatic logic pd_level(input logic pol);
        return ~pol;
    endfunction

    task automatic do_reset(input logic pol);
        @(negedge clk);
        rst_n = 1'b0;
        pol_mode_i = pol;
        test_mode_i = 1'b0;
        ctl_pin_i = pd_level(pol);
        cycles(2);
        rst_n = 1'b1;
        cycles(4);
    endtask

    task automatic set_straps(input logic [2:0] fs, input logic f, input logic d, input logic t);
        fs_i = fs; func_strap_i = f; dbg_strap_i = d; trust_strap_i = t;
    endtask

    task automatic t_reset_state();
        do_reset(1'b0);
        chk("R1", "locked", locked_o, 0);
        chk("R1", "pwrdn", pwrdn_o, 0);
        chk("R1", "freq", cpu_freq_o, 0);
        chk("R1", "rsvd", freq_rsvd_o, 0);
        chk("R1", "func", func_sel_o, 0);
        chk("R1", "dbg", dbg_sel_o, 0);
        chk("R1", "trust", trusted_o, 1);
    endtask

    task automatic t_lock_and_freeze(input logic pol);
        do_reset(pol);
        set_straps(3'b011, 1'b1, 1'b1, 1'b0);
        cycles(6);
        // R2: held at power-down level, nothing captured
        chk("R2", "no capture at pd level", locked_o, 0);
        chk("R2", "no pwrdn before lock", pwrdn_o, 0);
        ctl_pin_i = ~pd_level(pol);
        cycles(3);
        chk("R3", "locked after 3 edges", locked_o, 1);
        chk("R6", "freq 011", cpu_freq_o, 2);
        chk("R8", "func", func_sel_o, 1);
        chk("R8", "dbg", dbg_sel_o, 1);
        chk("R8", "trust", trusted_o, 0);
        chk("R5", "no pwrdn at good level", pwrdn_o, 0);
        // R4: change everything, straps frozen
        set_straps(3'b010, 1'b0, 1'b0, 1'b1);
        ctl_pin_i = pd_level(pol);
        cycles(3);
        chk("R5", "pwrdn live", pwrdn_o, 1);
        ctl_pin_i = ~pd_level(pol);
        cycles(3);
        chk("R5", "pwrdn released", pwrdn_o, 0);
        chk("R4", "freq frozen", cpu_freq_o, 2);
        chk("R4", "func frozen", func_sel_o, 1);
        chk("R4", "trust frozen", trusted_o, 0);
        chk("R4", "lock sticky", locked_o, 1);
    endtask

    task automatic t_freq(input logic [2:0] fs, input int exp_code, input int exp_rsvd);
        do_reset(1'b0);
        set_straps(fs, 1'b0, 1'b0, 1'b1);
        ctl_pin_i = 1'b0;
        cycles(4);
        chk(exp_rsvd ? "R7" : "R6", $sformatf("code %b", fs), cpu_freq_o, exp_code);
        chk(exp_rsvd ? "R7" : "R6", $sformatf("rsvd %b", fs), freq_rsvd_o, exp_rsvd);
    endtask

    task automatic t_test_mode();
        do_reset(1'b1);
        set_straps(3'b101, 1'b0, 1'b0, 1'b1);
        ctl_pin_i = 1'b1;
        cycles(4);
        chk("R10", "no tristate outside test", test_tristate_o, 0);
        chk("R10", "no refdiv outside test", test_refdiv_o, 0);
        test_mode_i = 1'b1;
        set_straps(3'b001, 1'b1, 1'b0, 1'b0);
        cycles(2);
        chk("R9", "live fs in test", cpu_freq_o, 1);
        chk("R9", "live func in test", func_sel_o, 1);
        chk("R10", "tristate FSB=0", test_tristate_o, 1);
        chk("R10", "refdiv FSB=0", test_refdiv_o, 0);
        fs_i = 3'b011;
        cycles(2);
        chk("R10", "refdiv FSB=1", test_refdiv_o, 1);
        chk("R10", "tristate FSB=1", test_tristate_o, 0);
        test_mode_i = 1'b0;
        fs_i = 3'b010;
        cycles(2);
        chk("R4", "frozen after test exit", cpu_freq_o, 2);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 20000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        t_reset_state();
        t_lock_and_freeze(1'b0);
        t_lock_and_freeze(1'b1);
        t_freq(3'b101, 0, 0);
        t_freq(3'b001, 1, 0);
        t_freq(3'b011, 2, 0);
        t_freq(3'b010, 3, 0);
        t_freq(3'b000, 0, 1);
        t_freq(3'b111, 0, 1);
        t_test_mode();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule